// File: doc/BRIEF.md
# Display program sequencer

This block is the control core of a programmable display fetch engine. On every clock it reads exactly one 16-bit word from a shared memory port. In the Execute state that word is decoded as an instruction. The instructions can load either of two 18-bit pixel fetch counters (low or high part), jump, set a reset-base page, set a palette page, or write one palette entry. A Run instruction moves the block to the Run state. In Run the block reads pixel words through the selected counter and pushes their 4-bit nibbles into an external pixel queue, until a programmed nibble count has been moved. It then returns to Execute.

A frame-reset pulse restarts the program once per frame. A blanking flag gates palette writes. A queue-space input reports how many nibble slots are free, and the block stalls a Run transfer until the current word's nibbles fit. Video timing and palette lookup sit outside this block.

States: `ST_EXEC` fetches at the program address and decodes. `ST_RUN` fetches through a counter and pushes nibbles. Transitions:
- EXEC→RUN happens on a Run word with a non-zero count.
- RUN→RUN happens while nibbles remain, or while the transfer is stalled.
- RUN→EXEC happens when the last nibble is pushed.
- Any state goes to EXEC on a frame reset.

Top module: `disp_seq`

## Requirements
- R1: On a frame reset both fetch counters and the palette page are cleared. The program address becomes {reset_base, 12'h000}, `q_flush_o` is high during the reset cycle and the state is EXEC. The asynchronous `rst_n` additionally clears the reset base and the palette select output.
- R2: In EXEC, `mem_addr_o` equals the program address, and the address increments by one after each executed instruction other than a jump. A word whose bits 15:14 are 10 changes nothing else.
- R3: A word 00_10_xxxxxxxxxxxx (bits 15:14 = 00, bits 13:12 = 10) replaces bits 11:0 of the program address with bits 11:0 of the word and keeps bits 15:12.
- R4: Each 18-bit counter holds {word address[15:0], nibble offset[1:0]}.
  - A word 00_0c_payload (c selects the counter) loads counter bits 11:0, which hold address bits 9:0 and the offset.
  - A word 01_0c_payload loads counter bits 17:6, which hold address bits 15:4.
  - The two fields overlap, and the later load wins on the shared bits.
  - In RUN, `mem_addr_o` is counter bits 17:2.
- R5: A word 01_10_xxxxxxxx_bbbb sets the 4-bit reset base, and the next frame reset uses it.
- R6: A word 01_11_xxxxxxxx_pppp sets the palette page. A word 00_11_iiii_dddddddd raises `pal_we_o` with address {page, iiii} and data dddddddd, but only when `blank_i` is high. Otherwise the word is ignored, although the program address still advances.
- R7: A Run word holds 11 in bits 15:14, the counter select in bit 13 (1 = counter 1), the palette select in bits 12:9 (driven on `psel_o` from the next cycle) and the nibble count N in bits 8:0. With N = 0 the block stays in EXEC.
- R8: In RUN, each cycle pushes k = min(4 − offset, remaining) nibbles.
  - `q_push_data_o` is the fetched word shifted left by 4·offset, so the first nibble is in bits 15:12. The nibbles of a word are taken from bit 15 downwards.
  - `q_push_cnt_o` equals k, the counter advances by k, and the program address holds.
  - After the last nibble the state returns to EXEC, and the counter points at the next unused nibble.
- R9: When `q_space_i` is less than k, nothing is pushed and the counter and `mem_addr_o` hold, until space is available.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_rst_i | input | 1 | Synchronous per-frame restart |
| blank_i | input | 1 | High while the display is blanked |
| mem_rdata_i | input | 16 | Word read at `mem_addr_o` in the same cycle |
| q_space_i | input | QS_W | Free nibble slots in the pixel queue |
| mem_addr_o | output | AW | Memory word address |
| q_flush_o | output | 1 | Empty the pixel queue |
| q_push_o | output | 1 | Push nibbles this cycle |
| q_push_cnt_o | output | 3 | Number of nibbles pushed (0 when idle) |
| q_push_data_o | output | 16 | Pushed nibbles, first in bits 15:12 |
| psel_o | output | 4 | Palette select nibble from the last Run |
| pal_we_o | output | 1 | Palette entry write strobe |
| pal_addr_o | output | 8 | Palette entry address |
| pal_data_o | output | 8 | Palette colour, rrrgggbb |

## Verification
The bench builds the block with its defaults: a 16-bit address, a 9-bit nibble count and a 3-bit queue-space input. The 3-bit space input reaches values 0 to 7. This allows a stall with space just below a four-nibble push (3), a release at exactly four, and free running with more space. The bench memory decodes only 12 address bits, so a counter loaded high into page 4, or a program restarted at base 3, aliases back onto the same small store. The exact address driven on the port is checked against the expected value.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

    typedef enum logic {
        ST_EXEC = 1'b0,
        ST_RUN  = 1'b1
    } dseq_state_e;

    typedef enum logic [1:0] {
        CL_LOAD   = 2'b00,
        CL_LOADHI = 2'b01,
        CL_RSVD   = 2'b10,
        CL_RUN    = 2'b11
    } op_class_e;

    typedef struct packed {
        logic ld_lo0;
        logic ld_lo1;
        logic ld_hi0;
        logic ld_hi1;
        logic jump;
        logic set_base;
        logic set_page;
        logic pal_wr;
        logic run;
    } dec_t;

endpackage

// File: rtl/dseq_decode.sv
module dseq_decode
    import dseq_pkg::*;
(
    input  logic [15:0] word_i,
    output dec_t        dec_o
);
    op_class_e cls;
    logic [1:0] sub;

    assign cls = op_class_e'(word_i[15:14]);
    assign sub = word_i[13:12];

    always_comb begin
        dec_o = '0;
        unique case (cls)
            CL_LOAD: begin
                unique case (sub)
                    2'b00: dec_o.ld_lo0 = 1'b1;
                    2'b01: dec_o.ld_lo1 = 1'b1;
                    2'b10: dec_o.jump   = 1'b1;
                    2'b11: dec_o.pal_wr = 1'b1;
                    default: ;
                endcase
            end
            CL_LOADHI: begin
                unique case (sub)
                    2'b00: dec_o.ld_hi0   = 1'b1;
                    2'b01: dec_o.ld_hi1   = 1'b1;
                    2'b10: dec_o.set_base = 1'b1;
                    2'b11: dec_o.set_page = 1'b1;
                    default: ;
                endcase
            end
            CL_RUN:  dec_o.run = 1'b1;
            CL_RSVD: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/dseq_counter.sv
module dseq_counter #(
    parameter int AW     = 16,
    parameter int PAY_W  = 12,
    parameter int STEP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              ld_lo_i,
    input  logic              ld_hi_i,
    input  logic [PAY_W-1:0]  payload_i,
    input  logic              adv_i,
    input  logic [STEP_W-1:0] step_i,
    output logic [AW+1:0]     val_o
);
    localparam int CW = AW + 2;

    logic [CW-1:0] val_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
        end else if (clr_i) begin
            val_q <= '0;
        end else if (ld_lo_i) begin
            val_q[PAY_W-1:0] <= payload_i;
        end else if (ld_hi_i) begin
            val_q[CW-1 -: PAY_W] <= payload_i;
        end else if (adv_i) begin
            val_q <= val_q + CW'(step_i);
        end
    end

    assign val_o = val_q;
endmodule

// File: rtl/dseq_nibble.sv
module dseq_nibble #(
    parameter int DW    = 16,
    parameter int NIB_W = 4,
    parameter int CNT_W = 9
) (
    input  logic [DW-1:0]                        word_i,
    input  logic [$clog2(DW/NIB_W)-1:0]          off_i,
    input  logic [CNT_W-1:0]                     remain_i,
    output logic [$clog2(DW/NIB_W+1)-1:0]        k_o,
    output logic [DW-1:0]                        data_o
);
    localparam int NPW   = DW / NIB_W;
    localparam int OFF_W = $clog2(NPW);
    localparam int K_W   = $clog2(NPW + 1);

    logic [K_W-1:0] avail;

    assign avail = K_W'(NPW) - K_W'(off_i);

    always_comb begin
        if (remain_i < CNT_W'(avail)) k_o = K_W'(remain_i);
        else                          k_o = avail;
    end

    assign data_o = word_i << (32'(off_i) * NIB_W);

    logic unused_off_w;
    assign unused_off_w = (OFF_W == 0);
endmodule

// File: rtl/disp_seq.sv
module disp_seq
    import dseq_pkg::*;
#(
    parameter int AW    = 16,
    parameter int CNT_W = 9,
    parameter int QS_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_rst_i,
    input  logic             blank_i,
    input  logic [15:0]      mem_rdata_i,
    input  logic [QS_W-1:0]  q_space_i,
    output logic [AW-1:0]    mem_addr_o,
    output logic             q_flush_o,
    output logic             q_push_o,
    output logic [2:0]       q_push_cnt_o,
    output logic [15:0]      q_push_data_o,
    output logic [3:0]       psel_o,
    output logic             pal_we_o,
    output logic [7:0]       pal_addr_o,
    output logic [7:0]       pal_data_o
);
    localparam int PAY_W  = 12;
    localparam int BASE_W = AW - PAY_W;
    localparam int CW     = AW + 2;
    localparam int NCTR   = 2;

    dseq_state_e        state_q, state_d;
    logic [AW-1:0]      pc_q, pc_d;
    logic [BASE_W-1:0]  base_q, base_d;
    logic [3:0]         page_q, page_d;
    logic [3:0]         psel_q, psel_d;
    logic               csel_q, csel_d;
    logic [CNT_W-1:0]   remain_q, remain_d;

    dec_t               dec;
    logic               exec_ok;
    logic               go;
    logic [2:0]         nib_k;
    logic [15:0]        nib_data;
    logic [CW-1:0]      ctr_val [NCTR];
    logic [CW-1:0]      cur_ctr;

    dseq_decode u_dec (.word_i(mem_rdata_i), .dec_o(dec));

    assign exec_ok = (state_q == ST_EXEC) && !frame_rst_i;
    assign cur_ctr = ctr_val[csel_q];

    generate
        for (genvar g = 0; g < NCTR; g++) begin : g_ctr
            logic ld_lo, ld_hi;
            assign ld_lo = exec_ok && ((g == 0) ? dec.ld_lo0 : dec.ld_lo1);
            assign ld_hi = exec_ok && ((g == 0) ? dec.ld_hi0 : dec.ld_hi1);
            dseq_counter #(.AW(AW), .PAY_W(PAY_W), .STEP_W(3)) u_ctr (
                .clk       (clk),
                .rst_n     (rst_n),
                .clr_i     (frame_rst_i),
                .ld_lo_i   (ld_lo),
                .ld_hi_i   (ld_hi),
                .payload_i (mem_rdata_i[PAY_W-1:0]),
                .adv_i     (go && (csel_q == g[0])),
                .step_i    (nib_k),
                .val_o     (ctr_val[g])
            );
        end
    endgenerate

    dseq_nibble #(.DW(16), .NIB_W(4), .CNT_W(CNT_W)) u_nib (
        .word_i   (mem_rdata_i),
        .off_i    (cur_ctr[1:0]),
        .remain_i (remain_q),
        .k_o      (nib_k),
        .data_o   (nib_data)
    );

    assign go = (state_q == ST_RUN) && !frame_rst_i
             && (int'(q_space_i) >= int'(nib_k));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_EXEC;
            pc_q     <= '0;
            base_q   <= '0;
            page_q   <= '0;
            psel_q   <= '0;
            csel_q   <= 1'b0;
            remain_q <= '0;
        end else begin
            state_q  <= state_d;
            pc_q     <= pc_d;
            base_q   <= base_d;
            page_q   <= page_d;
            psel_q   <= psel_d;
            csel_q   <= csel_d;
            remain_q <= remain_d;
        end
    end

    // Next state
    always_comb begin
        state_d  = state_q;
        pc_d     = pc_q;
        base_d   = base_q;
        page_d   = page_q;
        psel_d   = psel_q;
        csel_d   = csel_q;
        remain_d = remain_q;
        if (frame_rst_i) begin
            state_d = ST_EXEC;
            pc_d    = {base_q, {PAY_W{1'b0}}};
            page_d  = '0;
        end else begin
            unique case (state_q)
                ST_EXEC: begin
                    if (dec.jump) pc_d = {pc_q[AW-1:PAY_W], mem_rdata_i[PAY_W-1:0]};
                    else          pc_d = pc_q + AW'(1);
                    if (dec.set_base) base_d = mem_rdata_i[BASE_W-1:0];
                    if (dec.set_page) page_d = mem_rdata_i[3:0];
                    if (dec.run) begin
                        csel_d   = mem_rdata_i[13];
                        psel_d   = mem_rdata_i[12:9];
                        remain_d = mem_rdata_i[CNT_W-1:0];
                        if (mem_rdata_i[CNT_W-1:0] != '0) state_d = ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (go) begin
                        remain_d = remain_q - CNT_W'(nib_k);
                        if (remain_q == CNT_W'(nib_k)) state_d = ST_EXEC;
                    end
                end
                default: state_d = ST_EXEC;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_addr_o    = (state_q == ST_EXEC) ? pc_q : cur_ctr[CW-1:2];
        q_flush_o     = frame_rst_i;
        q_push_o      = go;
        q_push_cnt_o  = go ? nib_k : 3'd0;
        q_push_data_o = nib_data;
        psel_o        = psel_q;
        pal_we_o      = exec_ok && dec.pal_wr && blank_i;
        pal_addr_o    = {page_q, mem_rdata_i[11:8]};
        pal_data_o    = mem_rdata_i[7:0];
    end

    // Checks
    a_r6_pal_only_blank: assert property (@(posedge clk) disable iff (!rst_n)
        pal_we_o |-> blank_i);

    a_r9_no_overfill: assert property (@(posedge clk) disable iff (!rst_n)
        q_push_o |-> (int'(q_push_cnt_o) <= int'(q_space_i)));

    a_r8_push_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        q_push_o |-> (q_push_cnt_o != 3'd0 && q_push_cnt_o <= 3'd4));

    a_r1_frame_entry: assert property (@(posedge clk) disable iff (!rst_n)
        frame_rst_i |=> (state_q == ST_EXEC && mem_addr_o == {base_q, {PAY_W{1'b0}}}));

    a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !q_push_o && !frame_rst_i)
            |=> (state_q == ST_RUN && $stable(mem_addr_o)));

    a_r8_pc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !frame_rst_i) |=> $stable(pc_q));
endmodule

// File: tb/disp_seq_tb.sv
module disp_seq_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_rst = 1'b0;
    logic        blank = 1'b0;
    logic [15:0] mem_rdata;
    logic [2:0]  q_space = 3'd7;
    logic [15:0] mem_addr;
    logic        q_flush, q_push, pal_we;
    logic [2:0]  q_cnt;
    logic [15:0] q_data;
    logic [3:0]  psel;
    logic [7:0]  pal_addr, pal_data;

    logic [15:0] mem [0:4095];
    assign mem_rdata = mem[mem_addr[11:0]];

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [3:0] nib_log [0:63];
    int nib_cnt = 0;
    int pal_cnt = 0;
    logic [7:0] pal_a_last, pal_d_last;

    always #(CLK_P/2) clk = ~clk;

    disp_seq u_dut (
        .clk(clk), .rst_n(rst_n), .frame_rst_i(frame_rst), .blank_i(blank),
        .mem_rdata_i(mem_rdata), .q_space_i(q_space), .mem_addr_o(mem_addr),
        .q_flush_o(q_flush), .q_push_o(q_push), .q_push_cnt_o(q_cnt),
        .q_push_data_o(q_data), .psel_o(psel), .pal_we_o(pal_we),
        .pal_addr_o(pal_addr), .pal_data_o(pal_data)
    );

    always @(negedge clk) begin
        if (rst_n && q_push) begin
            for (int i = 0; i < int'(q_cnt); i++)
                if (nib_cnt + i < 64) nib_log[nib_cnt + i] = q_data[15 - 4*i -: 4];
            nib_cnt = nib_cnt + int'(q_cnt);
        end
        if (rst_n && pal_we) begin
            pal_cnt++;
            pal_a_last = pal_addr;
            pal_d_last = pal_data;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic clr_mem;
        for (int i = 0; i < 4096; i++) mem[i] = 16'h2000 | 16'(i);
    endtask

    task automatic restart;
        frame_rst = 1'b1;
        tick(1);
        frame_rst = 1'b0;
        nib_cnt = 0;
        pal_cnt = 0;
    endtask

    task automatic chk_nibs(input string req, input logic [3:0] e0, input logic [3:0] e1,
                            input logic [3:0] e2, input logic [3:0] e3);
        chk(req, "nibble 0", 32'(nib_log[0]), 32'(e0));
        chk(req, "nibble 1", 32'(nib_log[1]), 32'(e1));
        chk(req, "nibble 2", 32'(nib_log[2]), 32'(e2));
        chk(req, "nibble 3", 32'(nib_log[3]), 32'(e3));
    endtask

    task automatic t_reset;
        chk("R1", "addr after reset", 32'(mem_addr), 32'h0);
        chk("R1", "no push after reset", 32'(q_push), 32'h0);
        chk("R1", "psel after reset", 32'(psel), 32'h0);
    endtask

    task automatic t_run_basic;   // R7 R8
        clr_mem();
        mem[0] = 16'h0400; mem[1] = 16'hC606; mem[2] = 16'hC003; mem[3] = 16'h2003;
        mem[12'h100] = 16'h1234; mem[12'h101] = 16'h5678; mem[12'h102] = 16'h9ABC;
        restart();
        tick(12);
        chk("R8", "nibble total", 32'(nib_cnt), 32'd9);
        chk_nibs("R8", 4'h1, 4'h2, 4'h3, 4'h4);
        chk("R8", "nibble 5", 32'(nib_log[5]), 32'h6);
        chk("R8", "resume offset nibble 6", 32'(nib_log[6]), 32'h7);
        chk("R8", "resume offset nibble 7", 32'(nib_log[7]), 32'h8);
        chk("R8", "next word nibble 8", 32'(nib_log[8]), 32'h9);
        chk("R7", "psel from run", 32'(psel), 32'h0);
        chk("R2", "parked address", 32'(mem_addr), 32'h3);
    endtask

    task automatic t_psel_ctr1;   // R7 R4
        clr_mem();
        mem[0] = 16'h1413; mem[1] = 16'hE602; mem[2] = 16'h2002;
        mem[12'h104] = 16'hABCD; mem[12'h105] = 16'hEF01;
        restart();
        tick(8);
        chk("R7", "ctr1 nibble count", 32'(nib_cnt), 32'd2);
        chk("R4", "offset 3 first nibble", 32'(nib_log[0]), 32'hD);
        chk("R4", "wrap to next word", 32'(nib_log[1]), 32'hE);
        chk("R7", "psel value", 32'(psel), 32'h3);
    endtask

    task automatic t_overlap_stall;   // R4 R9
        clr_mem();
        q_space = 3'd0;
        mem[0] = 16'h4400; mem[1] = 16'h0008; mem[2] = 16'hC004; mem[3] = 16'h2003;
        restart();
        tick(6);
        chk("R4", "overlapped counter address", 32'(mem_addr), 32'h4002);
        chk("R9", "no push with zero space", 32'(nib_cnt), 32'd0);
        q_space = 3'd3;
        tick(3);
        chk("R9", "no push with space 3", 32'(nib_cnt), 32'd0);
        chk("R9", "address held in stall", 32'(mem_addr), 32'h4002);
        q_space = 3'd4;
        tick(3);
        chk("R9", "push after space", 32'(nib_cnt), 32'd4);
        chk_nibs("R9", 4'hC, 4'h0, 4'h0, 4'h4);
        chk("R8", "back to exec", 32'(mem_addr), 32'h3);
        q_space = 3'd7;
    endtask

    task automatic t_jump_pc;   // R2 R3 R7
        clr_mem();
        mem[0] = 16'h8123; mem[1] = 16'hC000; mem[2] = 16'h2010;
        restart();
        chk("R2", "start address", 32'(mem_addr), 32'h0);
        tick(1);
        chk("R2", "reserved class advances", 32'(mem_addr), 32'h1);
        tick(1);
        chk("R7", "zero count run advances", 32'(mem_addr), 32'h2);
        tick(1);
        chk("R3", "jump target", 32'(mem_addr), 32'h10);
        tick(2);
        chk("R7", "zero count pushes nothing", 32'(nib_cnt), 32'd0);
    endtask

    task automatic t_palette;   // R6
        clr_mem();
        blank = 1'b1;
        mem[0] = 16'h7005; mem[1] = 16'h3A5C; mem[2] = 16'h2002;
        restart();
        tick(5);
        chk("R6", "write count in blank", 32'(pal_cnt), 32'd1);
        chk("R6", "palette address", 32'(pal_a_last), 32'h5A);
        chk("R6", "palette data", 32'(pal_d_last), 32'h5C);
        blank = 1'b0;
        restart();
        tick(5);
        chk("R6", "ignored in active area", 32'(pal_cnt), 32'd0);
        chk("R6", "address advanced past ignored write", 32'(mem_addr), 32'h2);
        blank = 1'b1;
        mem[0] = 16'h7005; mem[1] = 16'h2001;
        restart();
        tick(3);
        mem[0] = 16'h3A5C;
        restart();
        tick(3);
        chk("R1", "page cleared by frame reset", 32'(pal_a_last), 32'h0A);
        blank = 1'b0;
    endtask

    task automatic t_frame;   // R1 R5
        clr_mem();
        mem[0] = 16'h6003; mem[1] = 16'h2001;
        restart();
        tick(4);
        frame_rst = 1'b1;
        #1;
        chk("R1", "flush during frame reset", 32'(q_flush), 32'h1);
        tick(1);
        frame_rst = 1'b0;
        chk("R5", "restart at base page", 32'(mem_addr), 32'h3000);
        mem[0] = 16'h6000;
        tick(3);
        restart();
        chk("R5", "base restored", 32'(mem_addr), 32'h0);
        mem[0] = 16'h0400; mem[1] = 16'h2001;
        restart();
        tick(3);
        mem[0] = 16'hC004;
        restart();
        tick(6);
        chk("R1", "counter cleared nibble count", 32'(nib_cnt), 32'd4);
        chk_nibs("R1", 4'hC, 4'h0, 4'h0, 4'h4);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        clr_mem();
        tick(3);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_run_basic();
        t_psel_ctr1();
        t_overlap_stall();
        t_jump_pc();
        t_palette();
        t_frame();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule